// File: doc/BRIEF.md
# Multi-Channel DMA Control and Status Register Block

This block holds the software-visible control and status state of a twelve-channel DMA controller. For every channel it stores an operating mode, a transfer direction and an interrupt enable. It also collects completion and error events from the channel engines into sticky flags, and it drives one shared interrupt line. The descriptor windows and the channel engines themselves sit outside the block. The block exposes the modes and directions to the engines and receives their done and error pulses and their two-bit progress state.

The channels are split into a lower group, channels 0 to 7, and an upper group, channels 8 to 11. Each group has its own control word and its own status word. Software reads a status word, handles the flagged channels and writes the same value back to clear exactly the flags it saw. A mode value of 3 in a control write means "leave this channel alone". Software can therefore change one channel without a read-modify-write on the shared word.

Top module: `dmac_csr`

## Requirements
- R1: Reset (synchronous, active high) clears every channel mode (0 = disabled), every direction, every interrupt enable, every interrupt and error flag, the read data and `irq`.
- R2: A write to offset 0x00 updates channel n (n < 8) from the four-bit field at data bits 4n+3:4n. Bits 1:0 of the field are the mode and bit 2 is the direction. The mode drives `ch_mode[2n+1:2n]` and the direction drives `ch_dir[n]`. A read of 0x00 returns each channel's mode and direction at the same positions, with bit 4n+3 reading 0.
- R3: Offset 0x0C does the same for channel n in 8..11, using the field at bits 4(n-8)+3:4(n-8). Bits 31:16 are ignored on write and read as 0. A write to 0x0C leaves channels 0 to 7 unchanged.
- R4: A field whose mode bits equal 3 leaves that channel's mode and direction unchanged. Fields holding 0, 1 or 2 in the same write are still applied.
- R5: Offset 0x08 holds the interrupt enables. Channel n uses bit n for n < 8 and bit n+8 for n >= 8. All other bits are ignored on write and read as 0.
- R6: A one-cycle pulse on `ch_done[n]` sets the channel's interrupt flag. A pulse on `ch_err[n]` sets both its interrupt flag and its error flag. Offset 0x10 shows channels 0 to 7 with the interrupt flag at bit n and the error flag at bit n+8. Offset 0x18 shows channels 8 to 11 the same way, indexed by n-8.
- R7: The flags are write-one-to-clear through their own status offset. A 0 bit leaves a flag untouched. A set event in the same cycle as a clear leaves the flag set. A clear written to one status offset never touches the other group's flags.
- R8: `ch_state[2n+1:2n]` is visible at bits 17+2n:16+2n of 0x10 for n < 8, and at bits 17+2(n-8):16+2(n-8) of 0x18 for n >= 8. Writes to these bits have no effect.
- R9: `irq` is high exactly one cycle after some channel has its interrupt flag and its enable both set. A flag whose enable is clear does not raise `irq`.
- R10: `reg_rdata` is loaded on the clock edge at which `reg_rd` is high, from the offset on `reg_addr` at that edge, and otherwise holds its value. Offsets 0x04 and 0x14, and all other unmapped offsets, read 0. Writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W (5) | Byte offset of the register |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Registered read data |
| ch_mode | output | 2*NUM_CH (24) | Mode per channel, two bits each |
| ch_dir | output | NUM_CH (12) | Direction per channel |
| ch_done | input | NUM_CH (12) | Completion pulse per channel |
| ch_err | input | NUM_CH (12) | Error pulse per channel |
| ch_state | input | 2*NUM_CH (24) | Progress state per channel, two bits each |
| irq | output | 1 | Shared registered interrupt |

## Verification
A control or enable write takes effect at the clock edge that samples it, and the new mode and direction are visible on the outputs right after that edge. Read data appears one edge after the read strobe. A done or error pulse sets its flag at its sampling edge, so `irq` moves one edge later, two edges after the pulse is driven. Likewise, `irq` falls one edge after the clearing write. The bench drives and samples on the falling edge. Each read request queues its expected word, which is popped and compared only on the falling edge that follows the capturing edge. Interrupt checks wait the extra cycle before looking at `irq`.

// File: rtl/dmac_csr_pkg.sv
package dmac_csr_pkg;

  localparam logic [4:0] OFS_CTL_LO  = 5'h00;
  localparam logic [4:0] OFS_SPARE_C = 5'h04;
  localparam logic [4:0] OFS_ENABLE  = 5'h08;
  localparam logic [4:0] OFS_CTL_HI  = 5'h0C;
  localparam logic [4:0] OFS_STS_LO  = 5'h10;
  localparam logic [4:0] OFS_SPARE_S = 5'h14;
  localparam logic [4:0] OFS_STS_HI  = 5'h18;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'd0,
    MODE_LIST   = 2'd1,
    MODE_SINGLE = 2'd2,
    MODE_KEEP   = 2'd3
  } chan_mode_e;

  localparam int FIELD_W  = 4;
  localparam int ERR_BASE = 8;
  localparam int ST_BASE  = 16;

  function automatic int enable_pos(input int n, input int lo_ch);
    return (n < lo_ch) ? n : n + lo_ch;
  endfunction

endpackage

// File: rtl/dmac_csr_chan.sv
module dmac_csr_chan
  import dmac_csr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ctl_we,
  input  logic [3:0] ctl_field,
  input  logic       en_we,
  input  logic       en_bit,
  input  logic       clr_we,
  input  logic       clr_irq,
  input  logic       clr_err,
  input  logic       done_i,
  input  logic       err_i,
  output logic [1:0] mode_o,
  output logic       dir_o,
  output logic       en_o,
  output logic       irq_flag_o,
  output logic       err_flag_o
);

  logic set_irq;
  logic keep_field;

  assign set_irq    = done_i | err_i;
  assign keep_field = (ctl_field[1:0] == MODE_KEEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_o     <= MODE_OFF;
      dir_o      <= 1'b0;
      en_o       <= 1'b0;
      irq_flag_o <= 1'b0;
      err_flag_o <= 1'b0;
    end else begin
      if (ctl_we && !keep_field) begin
        mode_o <= ctl_field[1:0];
        dir_o  <= ctl_field[2];
      end
      if (en_we) en_o <= en_bit;
      irq_flag_o <= set_irq | (irq_flag_o & ~(clr_we & clr_irq));
      err_flag_o <= err_i   | (err_flag_o & ~(clr_we & clr_err));
    end
  end

  AST_KEEP_MODE: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && ctl_field[1:0] == 2'b11) |=> ($stable(mode_o) && $stable(dir_o))); // R4
  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && ctl_field[1:0] != 2'b11) |=> (mode_o == $past(ctl_field[1:0]))); // R2
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !en_we |=> $stable(en_o)); // R5
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (done_i || err_i) |=> irq_flag_o); // R6
  AST_ERR_SETS: assert property (@(posedge clk) disable iff (rst)
    err_i |=> err_flag_o); // R6
  AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (clr_we && clr_irq && !done_i && !err_i) |=> !irq_flag_o); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (irq_flag_o && !(clr_we && clr_irq)) |=> irq_flag_o); // R7

endmodule

// File: rtl/dmac_csr_rdmux.sv
module dmac_csr_rdmux
  import dmac_csr_pkg::*;
#(
  parameter int NUM_CH = 12,
  parameter int LO_CH  = 8,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [2*NUM_CH-1:0] mode,
  input  logic [NUM_CH-1:0]   dir,
  input  logic [NUM_CH-1:0]   en,
  input  logic [NUM_CH-1:0]   irq_flag,
  input  logic [NUM_CH-1:0]   err_flag,
  input  logic [2*NUM_CH-1:0] state,
  output logic [DATA_W-1:0]   rdata
);

  localparam int HI_CH = NUM_CH - LO_CH;

  logic [DATA_W-1:0] w_ctl_lo, w_ctl_hi, w_en, w_sts_lo, w_sts_hi, w_sel;

  always_comb begin
    w_ctl_lo = '0;
    w_ctl_hi = '0;
    w_en     = '0;
    w_sts_lo = '0;
    w_sts_hi = '0;
    for (int l = 0; l < LO_CH; l++) begin
      w_ctl_lo[FIELD_W*l +: 2]   = mode[2*l +: 2];
      w_ctl_lo[FIELD_W*l + 2]    = dir[l];
      w_sts_lo[l]                = irq_flag[l];
      w_sts_lo[ERR_BASE + l]     = err_flag[l];
      w_sts_lo[ST_BASE + 2*l +: 2] = state[2*l +: 2];
    end
    for (int l = 0; l < HI_CH; l++) begin
      w_ctl_hi[FIELD_W*l +: 2]   = mode[2*(LO_CH+l) +: 2];
      w_ctl_hi[FIELD_W*l + 2]    = dir[LO_CH+l];
      w_sts_hi[l]                = irq_flag[LO_CH+l];
      w_sts_hi[ERR_BASE + l]     = err_flag[LO_CH+l];
      w_sts_hi[ST_BASE + 2*l +: 2] = state[2*(LO_CH+l) +: 2];
    end
    for (int n = 0; n < NUM_CH; n++) begin
      w_en[enable_pos(n, LO_CH)] = en[n];
    end
  end

  always_comb begin
    unique case (addr)
      ADDR_W'(OFS_CTL_LO): w_sel = w_ctl_lo;
      ADDR_W'(OFS_CTL_HI): w_sel = w_ctl_hi;
      ADDR_W'(OFS_ENABLE): w_sel = w_en;
      ADDR_W'(OFS_STS_LO): w_sel = w_sts_lo;
      ADDR_W'(OFS_STS_HI): w_sel = w_sts_hi;
      default:             w_sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= w_sel;
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata)); // R10
  AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (addr == ADDR_W'(OFS_SPARE_C) || addr == ADDR_W'(OFS_SPARE_S)))
      |=> (rdata == '0)); // R10

endmodule

// File: rtl/dmac_csr.sv
module dmac_csr
  import dmac_csr_pkg::*;
#(
  parameter int NUM_CH = 12,
  parameter int LO_CH  = 8,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic [2*NUM_CH-1:0] ch_mode,
  output logic [NUM_CH-1:0]   ch_dir,
  input  logic [NUM_CH-1:0]   ch_done,
  input  logic [NUM_CH-1:0]   ch_err,
  input  logic [2*NUM_CH-1:0] ch_state,
  output logic                irq
);

  logic [NUM_CH-1:0] en_vec, irq_vec, err_vec;
  logic              wr_ctl_lo, wr_ctl_hi, wr_en, wr_sts_lo, wr_sts_hi;
  logic              wdata_unused;

  assign wr_ctl_lo = reg_wr && (reg_addr == ADDR_W'(OFS_CTL_LO));
  assign wr_ctl_hi = reg_wr && (reg_addr == ADDR_W'(OFS_CTL_HI));
  assign wr_en     = reg_wr && (reg_addr == ADDR_W'(OFS_ENABLE));
  assign wr_sts_lo = reg_wr && (reg_addr == ADDR_W'(OFS_STS_LO));
  assign wr_sts_hi = reg_wr && (reg_addr == ADDR_W'(OFS_STS_HI));
  assign wdata_unused = ^reg_wdata;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    localparam bit LOW = (n < LO_CH);
    localparam int L   = LOW ? n : n - LO_CH;
    localparam int EP  = enable_pos(n, LO_CH);

    dmac_csr_chan u_chan (
      .clk        (clk),
      .rst        (rst),
      .ctl_we     (LOW ? wr_ctl_lo : wr_ctl_hi),
      .ctl_field  (reg_wdata[FIELD_W*L +: FIELD_W]),
      .en_we      (wr_en),
      .en_bit     (reg_wdata[EP]),
      .clr_we     (LOW ? wr_sts_lo : wr_sts_hi),
      .clr_irq    (reg_wdata[L]),
      .clr_err    (reg_wdata[ERR_BASE + L]),
      .done_i     (ch_done[n]),
      .err_i      (ch_err[n]),
      .mode_o     (ch_mode[2*n +: 2]),
      .dir_o      (ch_dir[n]),
      .en_o       (en_vec[n]),
      .irq_flag_o (irq_vec[n]),
      .err_flag_o (err_vec[n])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(irq_vec & en_vec);
  end

  dmac_csr_rdmux #(
    .NUM_CH (NUM_CH),
    .LO_CH  (LO_CH),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_rdmux (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (reg_rd),
    .addr     (reg_addr),
    .mode     (ch_mode),
    .dir      (ch_dir),
    .en       (en_vec),
    .irq_flag (irq_vec),
    .err_flag (err_vec),
    .state    (ch_state),
    .rdata    (reg_rdata)
  );

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (ch_mode == '0 && ch_dir == '0 && !irq && reg_rdata == '0)); // R1
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|(irq_vec & en_vec))); // R9
  AST_HI_WRITE_SPARES_LO: assert property (@(posedge clk) disable iff (rst)
    wr_ctl_hi |=> $stable(ch_mode[2*LO_CH-1:0])); // R3

endmodule

// File: tb/dmac_csr_bench.sv
module dmac_csr_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [23:0] ch_mode;
  logic [11:0] ch_dir;
  logic [11:0] ch_done = '0, ch_err = '0;
  logic [23:0] ch_state = '0;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmac_csr u_dmac_csr (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ch_mode(ch_mode), .ch_dir(ch_dir), .ch_done(ch_done),
    .ch_err(ch_err), .ch_state(ch_state), .irq(irq)
  );

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic pulse(input logic [11:0] d, input logic [11:0] e);
    @(negedge clk);
    ch_done = d; ch_err = e;
    @(negedge clk);
    ch_done = '0; ch_err = '0;
  endtask

  // monitor: the read captured at the last rising edge is compared here
  always @(posedge clk) rd_seen <= reg_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) check(reg_rdata, 32'hx, "R10 unexpected read");
      else check(reg_rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check({8'h0, ch_mode}, 32'h0, "R1 mode after reset");
    check({20'h0, ch_dir}, 32'h0, "R1 dir after reset");
    check({31'h0, irq}, 32'h0, "R1 irq after reset");
    check(reg_rdata, 32'h0, "R1 rdata after reset");
    rst = 1'b0;
    rd(5'h00, 32'h0, "R1 ctl lo reset");
    rd(5'h08, 32'h0, "R1 enable reset");
    rd(5'h10, 32'h0, "R1 status lo reset");

    // R2: ch0 mode1 dir1 (bit3 set, ignored), ch1 mode2, ch7 mode2 dir1
    wr(5'h00, 32'h6000_002D);
    check({16'h0, ch_mode[15:0]}, 32'h8009, "R2 ch_mode low group");
    check({24'h0, ch_dir[7:0]}, 32'h81, "R2 ch_dir low group");
    rd(5'h00, 32'h6000_0025, "R2 ctl lo readback");

    // R4: all fields 3 except ch1 -> mode1 dir0
    wr(5'h00, 32'h3333_3313);
    rd(5'h00, 32'h6000_0015, "R4 keep fields");
    check({16'h0, ch_mode[15:0]}, 32'h8005, "R4 ch_mode after keep write");
    check({24'h0, ch_dir[7:0]}, 32'h81, "R4 ch_dir after keep write");

    // R3: upper group
    wr(5'h0C, 32'hFFFF_6051);
    check({24'h0, ch_mode[23:16]}, 32'h85, "R3 ch_mode high group");
    check({28'h0, ch_dir[11:8]}, 32'hA, "R3 ch_dir high group");
    rd(5'h0C, 32'h0000_6051, "R3 ctl hi readback");
    rd(5'h00, 32'h6000_0015, "R3 low group untouched");

    // R5: enables
    wr(5'h08, 32'hFFFF_FFFF);
    rd(5'h08, 32'h000F_00FF, "R5 enable all");
    wr(5'h08, 32'h0004_0001);
    rd(5'h08, 32'h0004_0001, "R5 enable ch0 ch10");

    // R6/R8/R9: done on ch3 (not enabled)
    ch_state = 24'hAB_CDEF;
    pulse(12'h008, 12'h000);
    @(negedge clk);
    check({31'h0, irq}, 32'h0, "R9 disabled flag no irq");
    rd(5'h10, 32'hCDEF_0008, "R6 R8 status lo done ch3");

    // R6/R9: error on ch10 (enabled)
    pulse(12'h000, 12'h400);
    @(negedge clk);
    check({31'h0, irq}, 32'h1, "R9 irq from ch10");
    rd(5'h18, 32'h00AB_0404, "R6 status hi err ch10");

    // R7: clear in the other group leaves ch10
    wr(5'h10, 32'h0000_0004);
    rd(5'h18, 32'h00AB_0404, "R7 cross group clear ignored");
    wr(5'h18, 32'h0000_0400);
    rd(5'h18, 32'h00AB_0004, "R7 clear error only");
    check({31'h0, irq}, 32'h1, "R9 irq held while flag set");
    wr(5'h18, 32'h0000_0004);
    @(negedge clk);
    check({31'h0, irq}, 32'h0, "R9 irq falls after clear");
    rd(5'h18, 32'h00AB_0000, "R7 status hi cleared");

    // R7: clear then same-cycle set and clear
    wr(5'h10, 32'h0000_0008);
    rd(5'h10, 32'hCDEF_0000, "R7 ch3 cleared");
    @(negedge clk);
    ch_done = 12'h008; reg_wr = 1'b1; reg_addr = 5'h10; reg_wdata = 32'h8;
    @(negedge clk);
    ch_done = '0; reg_wr = 1'b0;
    rd(5'h10, 32'hCDEF_0008, "R7 set wins over clear");

    // R8/R10: state bits and spare offsets ignore writes
    wr(5'h10, 32'hFFFF_0000);
    rd(5'h10, 32'hCDEF_0008, "R8 state bits not writable");
    wr(5'h04, 32'hFFFF_FFFF);
    wr(5'h14, 32'hFFFF_FFFF);
    rd(5'h04, 32'h0, "R10 spare ctl reads zero");
    rd(5'h14, 32'h0, "R10 spare status reads zero");
    rd(5'h1C, 32'h0, "R10 unmapped reads zero");
    check({8'h0, ch_mode}, 32'h0085_8005, "R10 modes unchanged by spare writes");
    rd(5'h08, 32'h0004_0001, "R10 enables unchanged by spare writes");

    // R9: enabled lower channel, then R1 reset mid-run
    pulse(12'h001, 12'h000);
    @(negedge clk);
    check({31'h0, irq}, 32'h1, "R9 irq from ch0");
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check({8'h0, ch_mode}, 32'h0, "R1 modes cleared by reset");
    check({31'h0, irq}, 32'h0, "R1 irq cleared by reset");
    rd(5'h10, 32'hCDEF_0000, "R1 flags cleared by reset");
    rd(5'h08, 32'h0, "R1 enables cleared by reset");

    repeat (3) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule